// File: doc/BRIEF.md
# General-Purpose I/O Port Register Block

This block controls a parameterized port of general-purpose pins, sixteen by default. It holds four registers: a direction register, an output latch, an open-drain selector and a digital-select register. A simple write/read bus reaches them at separate addresses. From these registers the block computes, for each pin, a pad output-enable and a pad output value. It also passes the pad input levels through a capture stage and a synchronizer, so that software can read them back.

Reads of the port address return what the pins really carry, not what the latch holds. Pins left in analog mode read as zero and are never driven. Reset places every pin that has an analog function in analog mode. A pin can emulate an open-drain output: it pulls low when its latch bit is 0 and floats when the bit is 1.

A bit-set or bit-clear on the port address works as read-modify-write on the sampled pins. Back-to-back operations of that kind can therefore lose a bit that has not yet come back through the pin path. The same operations on the latch address work from the latch itself and lose nothing.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register reads all ones (every pin an input), and the latch, open-drain and digital-select registers read zero. Every pad output-enable is low.
- R2: A pin drives its pad only when three conditions hold: its direction bit is 0, it is digital, and it is not an open-drain pin whose latch bit is 1. A push-pull pin that drives puts its latch bit on the pad output.
- R3: A pin whose open-drain bit is 1 has pad output value 0. Its output-enable is the inverse of its latch bit, and this needs the pin to be a digital output.
- R4: A pin is analog when its digital-select bit is 0 and its bit in the parameter ANALOG_MASK is 1 (default 0x0FFF). An analog pin reads 0 at the port address and never drives its pad. Pins outside ANALOG_MASK are always digital.
- R5: A read of the port address (1) returns the synchronized pad input levels, masked by R4, and never the latch contents.
- R6: A pad input level present before rising edge k shows on port reads after edge k+SYNC_STAGES, which is edge k+2 by default. It does not show after edge k+1. A latch write at edge E therefore appears on looped-back pins after edge E+3, and a read after E+2 still returns the old level.
- R7: A plain write (op 0) to the latch address (2) or the port address (1) loads the output latch with the write data.
- R8: Bit-set (op 1) ORs the write data into the addressed register, and bit-clear (op 2) clears the bits set in the write data. On the latch address both operations start from the latch, so other bits keep their values. Op 3 changes nothing.
- R9: Bit-set and bit-clear on the port address start from the current port read value of R5 and R6, and the result goes into the latch.
- R10: Addresses 5 to 7 read as 0, and writes to them change no register.
- R11: Read data follows the address in the same cycle, with no wait state. The address map is: direction 0, port 1, latch 2, open-drain 3, digital-select 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Write strobe, sampled at the rising edge |
| bus_op_i | input | 2 | 0 write, 1 bit-set, 2 bit-clear, 3 no operation |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | WIDTH | Write data or bit mask |
| bus_rdata_o | output | WIDTH | Read data for bus_addr_i, same cycle |
| pad_in_i | input | WIDTH | Pad input levels, asynchronous |
| pad_oe_o | output | WIDTH | Pad output enable per pin |
| pad_out_o | output | WIDTH | Pad output value per pin |

## Verification
The pin path is exercised with a pad model that loops driven pins back and feeds an external level on the released pins. A port read whose high byte differs from the latch shows that pins, not the latch, are returned. Reads taken one edge before and exactly at the end of the capture chain expose an off-by-one in the pipeline. Two back-to-back bit-sets go once to the port address, where the first bit must be lost, and once to the latch address, where both must survive; this separates the two base operands. Further patterns cover open-drain with mixed latch bits, analog masking before and after digital-select is written, and writes to unmapped addresses.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_DIR  = 3'd0,
        REG_PORT = 3'd1,
        REG_LAT  = 3'd2,
        REG_ODC  = 3'd3,
        REG_DSEL = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_NONE  = 2'd3
    } bus_op_e;

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we_i,
    input  logic [1:0]        bus_op_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [WIDTH-1:0]  bus_wdata_i,
    input  logic [WIDTH-1:0]  port_val_i,
    output logic [WIDTH-1:0]  bus_rdata_o,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  lat_q,
    output logic [WIDTH-1:0]  odc_q,
    output logic [WIDTH-1:0]  dsel_q
);

    bus_op_e  op;
    reg_sel_e sel;
    logic     wr_act;

    assign op     = bus_op_e'(bus_op_i);
    assign sel    = reg_sel_e'(bus_addr_i);
    assign wr_act = bus_we_i && (op != OP_NONE);

    function automatic logic [WIDTH-1:0] modify(bus_op_e o, logic [WIDTH-1:0] base,
                                                logic [WIDTH-1:0] data);
        logic [WIDTH-1:0] r;
        case (o)
            OP_WRITE: r = data;
            OP_SET:   r = base | data;
            OP_CLEAR: r = base & ~data;
            default:  r = base;
        endcase
        return r;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '1;
            lat_q  <= '0;
            odc_q  <= '0;
            dsel_q <= '0;
        end else if (wr_act) begin
            case (sel)
                REG_DIR:  dir_q  <= modify(op, dir_q, bus_wdata_i);
                REG_PORT: lat_q  <= modify(op, port_val_i, bus_wdata_i);
                REG_LAT:  lat_q  <= modify(op, lat_q, bus_wdata_i);
                REG_ODC:  odc_q  <= modify(op, odc_q, bus_wdata_i);
                REG_DSEL: dsel_q <= modify(op, dsel_q, bus_wdata_i);
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            REG_DIR:  bus_rdata_o = dir_q;
            REG_PORT: bus_rdata_o = port_val_i;
            REG_LAT:  bus_rdata_o = lat_q;
            REG_ODC:  bus_rdata_o = odc_q;
            REG_DSEL: bus_rdata_o = dsel_q;
            default:  bus_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/gpio_port_pads.sv
module gpio_port_pads #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] dir_i,
    input  logic [WIDTH-1:0] lat_i,
    input  logic [WIDTH-1:0] odc_i,
    input  logic [WIDTH-1:0] dig_i,
    output logic [WIDTH-1:0] pad_oe_o,
    output logic [WIDTH-1:0] pad_out_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic is_out;
        assign is_out       = ~dir_i[i] & dig_i[i];
        assign pad_oe_o[i]  = is_out & ~(odc_i[i] & lat_i[i]);
        assign pad_out_o[i] = lat_i[i] & ~odc_i[i];
    end

endmodule

// File: rtl/gpio_port_insync.sv
module gpio_port_insync #(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_in_i,
    input  logic [WIDTH-1:0] dig_i,
    output logic [WIDTH-1:0] port_o
);

    // stage 0 is the loopback capture, stages 1..SYNC_STAGES the synchronizer
    logic [WIDTH-1:0] stage_q [0:SYNC_STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k <= SYNC_STAGES; k++) stage_q[k] <= '0;
        end else begin
            stage_q[0] <= pad_in_i;
            for (int k = 1; k <= SYNC_STAGES; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    assign port_o = stage_q[SYNC_STAGES] & dig_i;

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int               WIDTH       = 16,
    parameter int               SYNC_STAGES = 2,
    parameter logic [WIDTH-1:0] ANALOG_MASK = WIDTH'('h0FFF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we_i,
    input  logic [1:0]        bus_op_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [WIDTH-1:0]  bus_wdata_i,
    output logic [WIDTH-1:0]  bus_rdata_o,
    input  logic [WIDTH-1:0]  pad_in_i,
    output logic [WIDTH-1:0]  pad_oe_o,
    output logic [WIDTH-1:0]  pad_out_o
);

    logic [WIDTH-1:0] dir_q, lat_q, odc_q, dsel_q;
    logic [WIDTH-1:0] dig;
    logic [WIDTH-1:0] port_val;

    assign dig = dsel_q | ~ANALOG_MASK;

    gpio_port_regs #(.WIDTH(WIDTH)) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we_i    (bus_we_i),
        .bus_op_i    (bus_op_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .port_val_i  (port_val),
        .bus_rdata_o (bus_rdata_o),
        .dir_q       (dir_q),
        .lat_q       (lat_q),
        .odc_q       (odc_q),
        .dsel_q      (dsel_q)
    );

    gpio_port_pads #(.WIDTH(WIDTH)) i_pads (
        .dir_i     (dir_q),
        .lat_i     (lat_q),
        .odc_i     (odc_q),
        .dig_i     (dig),
        .pad_oe_o  (pad_oe_o),
        .pad_out_o (pad_out_o)
    );

    gpio_port_insync #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in_i (pad_in_i),
        .dig_i    (dig),
        .port_o   (port_val)
    );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int               WIDTH       = 16,
    parameter int               SYNC_STAGES = 2,
    parameter logic [WIDTH-1:0] ANALOG_MASK = WIDTH'('h0FFF)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we_i,
    input logic [1:0]        bus_op_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [WIDTH-1:0]  bus_wdata_i,
    input logic [WIDTH-1:0]  bus_rdata_o,
    input logic [WIDTH-1:0]  pad_in_i,
    input logic [WIDTH-1:0]  pad_oe_o,
    input logic [WIDTH-1:0]  pad_out_o,
    input logic [WIDTH-1:0]  dir_q,
    input logic [WIDTH-1:0]  lat_q,
    input logic [WIDTH-1:0]  odc_q,
    input logic [WIDTH-1:0]  dsel_q
);

    localparam int DEPTH = SYNC_STAGES + 1;
    localparam int CW    = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] hist [0:DEPTH-1];
    logic [CW-1:0]    cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc <= '0;
            for (int k = 0; k < DEPTH; k++) hist[k] <= '0;
        end else begin
            if (cyc != CW'(DEPTH)) cyc <= cyc + 1'b1;
            hist[0] <= pad_in_i;
            for (int k = 1; k < DEPTH; k++) hist[k] <= hist[k-1];
        end
    end

    a_r2_input_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe_o & dir_q) == '0);

    a_r3_od_released_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe_o & odc_q & lat_q) == '0);

    a_r3_od_out_low: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out_o & odc_q) == '0);

    a_r4_analog_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe_o & ~(dsel_q | ~ANALOG_MASK)) == '0);

    a_r6_port_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CW'(DEPTH) && bus_addr_i == REG_PORT)
        |-> bus_rdata_o == (hist[DEPTH-1] & (dsel_q | ~ANALOG_MASK)));

    a_r7_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && bus_op_i == OP_WRITE && (bus_addr_i == REG_LAT || bus_addr_i == REG_PORT))
        |=> lat_q == $past(bus_wdata_i));

    a_r8_latch_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && bus_op_i == OP_SET && bus_addr_i == REG_LAT)
        |=> lat_q == ($past(lat_q) | $past(bus_wdata_i)));

    a_r8_latch_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && bus_op_i == OP_CLEAR && bus_addr_i == REG_LAT)
        |=> lat_q == ($past(lat_q) & ~$past(bus_wdata_i)));

    a_r10_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && bus_addr_i > REG_DSEL)
        |=> ($stable(dir_q) && $stable(lat_q) && $stable(odc_q) && $stable(dsel_q)));

endmodule

bind gpio_port gpio_port_chk #(
    .WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES), .ANALOG_MASK(ANALOG_MASK)
) i_chk (.*);

// File: tb/test_gpio_port.sv
module test_gpio_port;

    localparam int          W     = 16;
    localparam logic [15:0] AMASK = 16'h0FFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_op = 2'd0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] pad_in, pad_oe, pad_out;
    logic [15:0] ext = '0;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    // pad model: driven pins loop back, released pins take the external level
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    gpio_port i_gpio_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we_i    (bus_we),
        .bus_op_i    (bus_op),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .pad_in_i    (pad_in),
        .pad_oe_o    (pad_oe),
        .pad_out_o   (pad_out)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [1:0] op, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_op = op; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; bus_op = 2'd3;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        @(negedge clk);
        rd(3'd0, d); check("R1 dir", d, 16'hFFFF);
        rd(3'd2, d); check("R1 lat", d, 16'h0000);
        rd(3'd3, d); check("R1 odc", d, 16'h0000);
        rd(3'd4, d); check("R1 dsel", d, 16'h0000);
        check("R1 oe", pad_oe, 16'h0000);
    endtask

    task automatic t_push_pull();
        logic [15:0] d;
        wr(3'd4, 2'd0, 16'hFFFF);
        wr(3'd0, 2'd0, 16'hFF00);
        wr(3'd2, 2'd0, 16'h00A5);
        check("R2 oe", pad_oe, 16'h00FF);
        check("R2 out", pad_out, 16'h00A5);
        wr(3'd1, 2'd0, 16'h005A);
        rd(3'd2, d); check("R7 port-address write", d, 16'h005A);
    endtask

    task automatic t_latency();
        logic [15:0] d;
        ext = 16'hC300;
        settle();
        wr(3'd2, 2'd0, 16'h0033);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rd(3'd1, d); check("R6 old level after E+2", d, 16'hC35A);
        @(posedge clk);
        @(negedge clk);
        rd(3'd1, d); check("R6 new level after E+3", d, 16'hC333);
        rd(3'd2, d); check("R5 latch differs from pins", d, 16'h0033);
    endtask

    task automatic t_latch_setclr();
        logic [15:0] d;
        wr(3'd2, 2'd0, 16'h0000);
        wr(3'd2, 2'd1, 16'h0002);
        wr(3'd2, 2'd1, 16'h0040);
        rd(3'd2, d); check("R8 latch set back-to-back", d, 16'h0042);
        wr(3'd2, 2'd2, 16'h0002);
        rd(3'd2, d); check("R8 latch clear", d, 16'h0040);
        wr(3'd2, 2'd3, 16'hFFFF);
        rd(3'd2, d); check("R8 op 3 ignored", d, 16'h0040);
    endtask

    task automatic t_port_rmw();
        logic [15:0] d;
        wr(3'd2, 2'd0, 16'h0000);
        settle();
        wr(3'd1, 2'd1, 16'h0002);
        wr(3'd1, 2'd1, 16'h0040);
        rd(3'd2, d); check("R9 port set reads pins", d, {ext[15:8], 8'h00} | 16'h0040);
        settle();
        wr(3'd1, 2'd2, 16'h4000);
        rd(3'd2, d); check("R9 port clear reads pins", d, 16'h8340);
    endtask

    task automatic t_open_drain();
        wr(3'd3, 2'd0, 16'h000F);
        wr(3'd2, 2'd0, 16'h0005);
        check("R3 oe", pad_oe, 16'h00FA);
        check("R3 out", pad_out, 16'h0000);
        wr(3'd3, 2'd0, 16'h0000);
    endtask

    task automatic t_analog();
        logic [15:0] d;
        wr(3'd4, 2'd0, 16'h0000);
        wr(3'd0, 2'd0, 16'h0000);
        wr(3'd2, 2'd0, 16'hFFFF);
        check("R4 analog pins released", pad_oe, ~AMASK);
        wr(3'd0, 2'd0, 16'hFFFF);
        ext = 16'hFFFF;
        settle();
        rd(3'd1, d); check("R4 analog reads zero", d, ~AMASK);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 3'd4; bus_op = 2'd0; bus_wdata = 16'hFFFF;
        @(posedge clk);
        #1 bus_we = 1'b0; bus_op = 2'd3; bus_addr = 3'd1;
        #1 check("R11 same-cycle port read", bus_rdata, 16'hFFFF);
    endtask

    task automatic t_unmapped();
        logic [15:0] d0, d2, d3, d4, d;
        @(negedge clk);
        rd(3'd0, d0); rd(3'd2, d2); rd(3'd3, d3); rd(3'd4, d4);
        wr(3'd5, 2'd0, 16'h1234);
        wr(3'd7, 2'd1, 16'hFFFF);
        wr(3'd6, 2'd2, 16'hFFFF);
        rd(3'd0, d); check("R10 dir kept", d, d0);
        rd(3'd2, d); check("R10 lat kept", d, d2);
        rd(3'd3, d); check("R10 odc kept", d, d3);
        rd(3'd4, d); check("R10 dsel kept", d, d4);
        rd(3'd6, d); check("R10 unmapped reads zero", d, 16'h0000);
    endtask

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bus_op = 2'd3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_push_pull();
        t_latency();
        t_latch_setclr();
        t_port_rmw();
        t_open_drain();
        t_analog();
        t_unmapped();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule